// File: doc/BRIEF.md
# Variable-length instruction byte parser

The parser accepts an instruction byte stream, one byte per cycle under a valid/ready handshake, and cuts each instruction into its fields: up to a fixed number of prefix bytes in any order, a one- or two-byte opcode, an optional addressing byte with an optional scaled-index byte, a displacement of 0, 1, 2 or 4 bytes and an immediate of 0, 1, 2 or 4 bytes. How long each later field is depends only on bytes already seen, so the parser walks the fields with a small sequencer and never looks ahead.

Whether an opcode carries an addressing byte, and how wide its immediate is, comes from an external attribute source. The parser samples the attribute inputs in the cycle the final opcode byte is accepted and ignores them in every other cycle. Once the last byte of an instruction is in, the parser forms one output record and holds it until the consumer takes it; input is back-pressured during that time. A run of too many prefixes raises a one-cycle error flag and makes the parser discard bytes until a byte marked as the start of a new instruction arrives.

Top module: `instr_parser`

## Requirements
- R1: Prefix bytes are classified as follows: F0h gives out_lockrep=1 (lock), F2h gives out_lockrep=2 (repeat-while-not-equal), F3h gives out_lockrep=3 (repeat / repeat-while-equal), 2Eh gives out_seg=1 (CS override), 36h gives out_seg=2 (SS override); 0 means absent. Prefixes are accepted in any order.
- R2: F0h, F2h and F3h form one group and 2Eh, 36h another; when a group appears more than once in one instruction the last byte of that group determines its field and out_dup is 1, otherwise out_dup is 0.
- R3: At most MAX_PFX (default 4) prefixes are accepted. A further prefix byte produces no record, drives err_flag high for exactly the following cycle, and from then on bytes are accepted and discarded (in_ready stays 1) until a byte with in_sop=1, which is parsed as the first byte of a new instruction with an empty prefix count. in_sop has no effect outside this discarding phase.
- R4: A first opcode byte of 0Fh means a second opcode byte follows; then out_two_byte=1 and out_opcode={0Fh, second byte}, otherwise out_two_byte=0 and out_opcode={00h, opcode byte}.
- R5: attr_modrm and attr_imm are used only in the cycle the final opcode byte is accepted. attr_modrm=1 means an addressing byte follows (out_modrm_v=1); attr_imm codes 0,1,2,3 mean 0,1,2,4 immediate bytes.
- R6: The addressing byte is reported as out_mod=bits 7:6, out_reg=bits 5:3, out_rm=bits 2:0; without it these fields, out_sib_v and out_disp are 0.
- R7: An index byte follows exactly when out_mod is not 3 and out_rm is 4; it is reported as out_scale=bits 7:6, out_index=bits 5:3, out_base=bits 2:0 with out_sib_v=1.
- R8: Displacement length is 1 byte for mod 1, 4 bytes for mod 2, 4 bytes for mod 0 with r/m 5 (no index byte) or with an index byte whose base is 5, and 0 otherwise. It is assembled little-endian and zero-extended into out_disp.
- R9: The immediate is assembled little-endian and zero-extended into out_imm.
- R10: out_len equals the number of bytes of the instruction, prefixes included (at most MAX_PFX+12).
- R11: While out_valid is 1 and out_ready is 0 the record is held unchanged; in_ready is 0 whenever a record is pending or being formed; the record is dropped in the cycle after out_ready is seen with out_valid. After reset out_valid=0, err_flag=0 and in_ready=1.
- R12: out_valid rises two cycles after the edge that accepts an instruction's last byte (one formation cycle, then the record).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can take a byte |
| in_byte | input | 8 | Instruction byte |
| in_sop | input | 1 | Marks the first byte of an instruction |
| attr_modrm | input | 1 | Current opcode has an addressing byte |
| attr_imm | input | 2 | Immediate size code of the current opcode |
| out_valid | output | 1 | Record pending |
| out_ready | input | 1 | Consumer takes the record |
| out_lockrep | output | 2 | Lock/repeat prefix code |
| out_seg | output | 2 | Segment override code |
| out_dup | output | 1 | A prefix group repeated |
| out_two_byte | output | 1 | Opcode is two bytes |
| out_opcode | output | 16 | Opcode bytes |
| out_modrm_v | output | 1 | Addressing byte present |
| out_mod | output | 2 | Addressing mode |
| out_reg | output | 3 | Register / opcode extension |
| out_rm | output | 3 | Register/memory selector |
| out_sib_v | output | 1 | Index byte present |
| out_scale | output | 2 | Index scale |
| out_index | output | 3 | Index register |
| out_base | output | 3 | Base register |
| out_disp | output | 32 | Displacement |
| out_imm | output | 32 | Immediate |
| out_len | output | LEN_W | Instruction length in bytes |
| err_flag | output | 1 | Prefix limit exceeded (one-cycle pulse) |

## Verification
A record is due on the second falling edge after the rising edge that takes the last byte; the bench checks that out_valid is still low and in_ready is low at the first falling edge, and that the full record is present at the second. err_flag is due at the first falling edge after the edge that takes the excess prefix and must be gone at the next one, and a released record must be gone at the first falling edge after the edge where out_ready was high. All sampling happens on falling edges, with inputs driven there too, so each check lands in a known cycle.

// File: rtl/ip_pkg.sv
package ip_pkg;

  typedef enum logic [2:0] {
    ST_PFX, ST_OP2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_DONE, ST_DROP
  } seq_st_e;

  typedef struct packed {
    logic        two_byte;
    logic [15:0] opcode;
    logic        modrm_v;
    logic [7:0]  modrm;
    logic        sib_v;
    logic [7:0]  sib;
    logic [31:0] disp;
    logic [31:0] imm;
  } body_t;

  localparam logic [7:0] BYTE_ESC = 8'h0F;

  // lock/repeat group code: 0 none, 1 lock, 2 rep-ne, 3 rep
  function automatic logic [1:0] lockrep_code(input logic [7:0] b);
    case (b)
      8'hF0:   return 2'd1;
      8'hF2:   return 2'd2;
      8'hF3:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // segment group code: 0 none, 1 CS, 2 SS
  function automatic logic [1:0] seg_code(input logic [7:0] b);
    case (b)
      8'h2E:   return 2'd1;
      8'h36:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] imm_bytes(input logic [1:0] c);
    return (c == 2'd3) ? 3'd4 : {1'b0, c};
  endfunction

  function automatic logic sib_follows(input logic [1:0] md, input logic [2:0] rm);
    return (md != 2'b11) && (rm == 3'b100);
  endfunction

  function automatic logic [2:0] disp_for(input logic [1:0] md, input logic no_base);
    case (md)
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      2'b00:   return no_base ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  function automatic seq_st_e after_opcode(input logic has_m, input logic [1:0] ic);
    if (has_m)                return ST_MODRM;
    if (imm_bytes(ic) != 3'd0) return ST_IMM;
    return ST_DONE;
  endfunction

  function automatic seq_st_e after_addr(input logic [2:0] dsz, input logic [2:0] isz);
    if (dsz != 3'd0) return ST_DISP;
    if (isz != 3'd0) return ST_IMM;
    return ST_DONE;
  endfunction

endpackage

// File: rtl/ip_prefix_acc.sv
module ip_prefix_acc import ip_pkg::*; #(
  parameter  int MAX_PFX = 4,
  localparam int CNT_W   = $clog2(MAX_PFX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] byt,
  output logic       is_pfx,
  output logic       full,
  output logic [1:0] lockrep,
  output logic [1:0] seg,
  output logic       dup
);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       lr_in, sg_in;

  assign lr_in  = lockrep_code(byt);
  assign sg_in  = seg_code(byt);
  assign is_pfx = (lr_in != 2'd0) || (sg_in != 2'd0);
  assign full   = (cnt == CNT_W'(MAX_PFX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; lockrep <= '0; seg <= '0; dup <= 1'b0;
    end else if (clr) begin
      cnt <= '0; lockrep <= '0; seg <= '0; dup <= 1'b0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (lr_in != 2'd0) begin
        if (lockrep != 2'd0) dup <= 1'b1;
        lockrep <= lr_in;
      end
      if (sg_in != 2'd0) begin
        if (seg != 2'd0) dup <= 1'b1;
        seg <= sg_in;
      end
    end
  end

  p_pfx_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_PFX));

  p_take_when_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> (cnt != '0));

endmodule

// File: rtl/ip_field_seq.sv
module ip_field_seq import ip_pkg::*; #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sop,
  input  logic [7:0]       byt,
  input  logic             attr_modrm,
  input  logic [1:0]       attr_imm,
  input  logic             is_pfx,
  input  logic             pfx_full,
  input  logic             hold_free,
  output logic             take_pfx,
  output logic             err,
  output logic             done,
  output logic             release_rec,
  output body_t            body,
  output logic [LEN_W-1:0] len_o
);

  seq_st_e          st, st_eff;
  body_t            wk;
  logic [2:0]       dsz, isz, d_modrm, d_sib;
  logic [1:0]       bcnt;
  logic [LEN_W-1:0] len;
  logic             at_head, clr_all, last_chunk;

  // a start marker seen while discarding turns the byte into a fresh head byte
  assign st_eff      = (st == ST_DROP && sop) ? ST_PFX : st;
  assign at_head     = (st_eff == ST_PFX);
  assign take_pfx    = acc && at_head && is_pfx && !pfx_full;
  assign err         = acc && at_head && is_pfx && pfx_full;
  assign done        = (st == ST_DONE);
  assign release_rec = done && hold_free;
  assign clr_all     = err || release_rec;

  assign d_modrm    = disp_for(byt[7:6], byt[2:0] == 3'b101);
  assign d_sib      = disp_for(wk.modrm[7:6], byt[2:0] == 3'b101);
  assign last_chunk = ({1'b0, bcnt} == (((st == ST_DISP) ? dsz : isz) - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_PFX; wk <= '0; dsz <= '0; isz <= '0; bcnt <= '0; len <= '0;
    end else if (clr_all) begin
      wk <= '0; dsz <= '0; isz <= '0; bcnt <= '0; len <= '0;
      st <= err ? ST_DROP : ST_PFX;
    end else if (acc) begin
      if (st_eff != ST_DROP) len <= len + 1'b1;
      case (st_eff)
        ST_PFX: begin
          if (is_pfx) begin
            st <= ST_PFX;
          end else begin
            wk.opcode <= {8'h00, byt};
            if (byt == BYTE_ESC) begin
              wk.two_byte <= 1'b1;
              st          <= ST_OP2;
            end else begin
              isz <= imm_bytes(attr_imm);
              st  <= after_opcode(attr_modrm, attr_imm);
            end
          end
        end
        ST_OP2: begin
          wk.opcode <= {wk.opcode[7:0], byt};
          isz       <= imm_bytes(attr_imm);
          st        <= after_opcode(attr_modrm, attr_imm);
        end
        ST_MODRM: begin
          wk.modrm_v <= 1'b1;
          wk.modrm   <= byt;
          dsz        <= d_modrm;
          st         <= sib_follows(byt[7:6], byt[2:0]) ? ST_SIB : after_addr(d_modrm, isz);
        end
        ST_SIB: begin
          wk.sib_v <= 1'b1;
          wk.sib   <= byt;
          dsz      <= d_sib;
          st       <= after_addr(d_sib, isz);
        end
        ST_DISP: begin
          wk.disp[{bcnt, 3'b000} +: 8] <= byt;
          if (last_chunk) begin
            bcnt <= '0;
            st   <= (isz != 3'd0) ? ST_IMM : ST_DONE;
          end else begin
            bcnt <= bcnt + 2'd1;
          end
        end
        ST_IMM: begin
          wk.imm[{bcnt, 3'b000} +: 8] <= byt;
          if (last_chunk) begin
            bcnt <= '0;
            st   <= ST_DONE;
          end else begin
            bcnt <= bcnt + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign body  = wk;
  assign len_o = len;

  p_err_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (st == ST_DROP));

  p_no_accept_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !acc);

  p_chunk_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DISP || st == ST_IMM) |-> ({1'b0, bcnt} < ((st == ST_DISP) ? dsz : isz)));

endmodule

// File: rtl/ip_rec_hold.sv
module ip_rec_hold import ip_pkg::*; #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ready,
  input  body_t            body_i,
  input  logic [1:0]       lr_i,
  input  logic [1:0]       seg_i,
  input  logic             dup_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             valid,
  output body_t            body_o,
  output logic [1:0]       lr_o,
  output logic [1:0]       seg_o,
  output logic             dup_o,
  output logic [LEN_W-1:0] len_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; body_o <= '0; lr_o <= '0; seg_o <= '0; dup_o <= 1'b0; len_o <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      body_o <= body_i;
      lr_o   <= lr_i;
      seg_o  <= seg_i;
      dup_o  <= dup_i;
      len_o  <= len_i;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(body_o) && $stable(len_o) && $stable(lr_o) && $stable(seg_o)));

  p_len_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len_i != '0));

endmodule

// File: rtl/instr_parser.sv
module instr_parser import ip_pkg::*; #(
  parameter  int MAX_PFX = 4,
  localparam int MAX_LEN = MAX_PFX + 12,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  input  logic             in_sop,
  input  logic             attr_modrm,
  input  logic [1:0]       attr_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_lockrep,
  output logic [1:0]       out_seg,
  output logic             out_dup,
  output logic             out_two_byte,
  output logic [15:0]      out_opcode,
  output logic             out_modrm_v,
  output logic [1:0]       out_mod,
  output logic [2:0]       out_reg,
  output logic [2:0]       out_rm,
  output logic             out_sib_v,
  output logic [1:0]       out_scale,
  output logic [2:0]       out_index,
  output logic [2:0]       out_base,
  output logic [31:0]      out_disp,
  output logic [31:0]      out_imm,
  output logic [LEN_W-1:0] out_len,
  output logic             err_flag
);

  logic             acc, is_pfx, pfx_full, take_pfx, err, seq_done, release_rec;
  logic [1:0]       lr_w, seg_w;
  logic             dup_w;
  body_t            body_w, body_q;
  logic [LEN_W-1:0] len_w;

  assign in_ready = !seq_done && !out_valid;
  assign acc      = in_valid && in_ready;

  ip_prefix_acc #(.MAX_PFX(MAX_PFX)) u_pfx (
    .clk(clk), .rst_n(rst_n), .clr(err || release_rec), .take(take_pfx), .byt(in_byte),
    .is_pfx(is_pfx), .full(pfx_full), .lockrep(lr_w), .seg(seg_w), .dup(dup_w)
  );

  ip_field_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sop(in_sop), .byt(in_byte),
    .attr_modrm(attr_modrm), .attr_imm(attr_imm), .is_pfx(is_pfx), .pfx_full(pfx_full),
    .hold_free(!out_valid), .take_pfx(take_pfx), .err(err), .done(seq_done),
    .release_rec(release_rec), .body(body_w), .len_o(len_w)
  );

  ip_rec_hold #(.LEN_W(LEN_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(release_rec), .ready(out_ready),
    .body_i(body_w), .lr_i(lr_w), .seg_i(seg_w), .dup_i(dup_w), .len_i(len_w),
    .valid(out_valid), .body_o(body_q), .lr_o(out_lockrep), .seg_o(out_seg),
    .dup_o(out_dup), .len_o(out_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= err;
  end

  assign out_two_byte = body_q.two_byte;
  assign out_opcode   = body_q.opcode;
  assign out_modrm_v  = body_q.modrm_v;
  assign out_mod      = body_q.modrm[7:6];
  assign out_reg      = body_q.modrm[5:3];
  assign out_rm       = body_q.modrm[2:0];
  assign out_sib_v    = body_q.sib_v;
  assign out_scale    = body_q.sib[7:6];
  assign out_index    = body_q.sib[5:3];
  assign out_base     = body_q.sib[2:0];
  assign out_disp     = body_q.disp;
  assign out_imm      = body_q.imm;

  p_sib_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sib_v == (out_modrm_v && out_mod != 2'b11 && out_rm == 3'b100)));

  p_reg_mode_nodisp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_modrm_v && out_mod == 2'b11) |-> (out_disp == 32'h0));

  p_no_addr_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_modrm_v) |-> (!out_sib_v && out_disp == 32'h0 && out_mod == 2'b00));

  p_record_due_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !out_valid) |=> out_valid);

  p_len_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len <= LEN_W'(MAX_LEN)));

  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> !err_flag);

endmodule

// File: tb/sim_instr_parser.sv
module sim_instr_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, attr_modrm = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [1:0]  attr_imm = 2'd0;
  logic        in_ready, out_valid, out_dup, out_two_byte, out_modrm_v, out_sib_v, err_flag;
  logic [1:0]  out_lockrep, out_seg, out_mod, out_scale;
  logic [2:0]  out_reg, out_rm, out_index, out_base;
  logic [15:0] out_opcode;
  logic [31:0] out_disp, out_imm;
  logic [4:0]  out_len;

  instr_parser u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_sop(in_sop), .attr_modrm(attr_modrm), .attr_imm(attr_imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_lockrep(out_lockrep), .out_seg(out_seg), .out_dup(out_dup),
    .out_two_byte(out_two_byte), .out_opcode(out_opcode), .out_modrm_v(out_modrm_v),
    .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm), .out_sib_v(out_sib_v),
    .out_scale(out_scale), .out_index(out_index), .out_base(out_base), .out_disp(out_disp),
    .out_imm(out_imm), .out_len(out_len), .err_flag(err_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0]  ib [0:15];
  int          nb, opc_last;
  logic        e_am;
  logic [1:0]  e_ai, e_lr, e_seg;
  logic        e_dup, e_two, e_mv, e_sv;
  logic [15:0] e_opc;
  logic [7:0]  e_modrm, e_sib;
  logic [31:0] e_disp, e_imm;
  bit          g1_seen, sg_seen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic begin_instr();
    nb = 0; opc_last = 0; e_am = 0; e_ai = 0; e_lr = 0; e_seg = 0; e_dup = 0; e_two = 0;
    e_mv = 0; e_sv = 0; e_opc = 0; e_modrm = 0; e_sib = 0; e_disp = 0; e_imm = 0;
    g1_seen = 0; sg_seen = 0;
  endtask

  task automatic add_byte(input logic [7:0] b);
    ib[nb] = b;
    nb++;
  endtask

  task automatic add_pfx(input logic [7:0] b);
    add_byte(b);
    if (b == 8'hF0 || b == 8'hF2 || b == 8'hF3) begin
      if (g1_seen) e_dup = 1;
      g1_seen = 1;
      e_lr = (b == 8'hF0) ? 2'd1 : (b == 8'hF2) ? 2'd2 : 2'd3;
    end else begin
      if (sg_seen) e_dup = 1;
      sg_seen = 1;
      e_seg = (b == 8'h2E) ? 2'd1 : 2'd2;
    end
  endtask

  task automatic add_pfx_set(input int s);
    case (s)
      1: add_pfx(8'hF0);
      2: begin add_pfx(8'h36); add_pfx(8'hF2); end
      3: begin add_pfx(8'hF3); add_pfx(8'h2E); add_pfx(8'hF0); add_pfx(8'h36); end
      4: begin add_pfx(8'h2E); add_pfx(8'hF2); end
      5: begin add_pfx(8'hF2); add_pfx(8'hF3); end
      default: ;
    endcase
  endtask

  task automatic add_opcode(input bit two, input logic [7:0] op, input logic am, input logic [1:0] ai);
    if (two) add_byte(8'h0F);
    opc_last = nb;
    add_byte(op);
    e_two = two;
    e_opc = two ? {8'h0F, op} : {8'h00, op};
    e_am  = am;
    e_ai  = ai;
  endtask

  task automatic add_addr(input int md, input int rg, input int rm, input int base, input int seed);
    int dn;
    logic [7:0] b;
    b = {md[1:0], rg[2:0], rm[2:0]};
    add_byte(b);
    e_mv = 1; e_modrm = b;
    if (md != 3 && rm == 4) begin
      b = {seed[1:0], seed[4:2], base[2:0]};
      add_byte(b);
      e_sv = 1; e_sib = b;
    end
    if (md == 1) dn = 1;
    else if (md == 2) dn = 4;
    else if (md == 0 && (rm == 5 || (rm == 4 && base == 5))) dn = 4;
    else dn = 0;
    for (int i = 0; i < dn; i++) begin
      b = 8'(seed * 13 + i * 8'h31 + 8'h07);
      add_byte(b);
      e_disp = e_disp | (32'(b) << (8 * i));
    end
  endtask

  task automatic add_imm(input logic [1:0] ai, input int seed);
    int n;
    logic [7:0] b;
    n = (ai == 2'd3) ? 4 : int'(ai);
    for (int i = 0; i < n; i++) begin
      b = 8'(seed * 29 + i * 8'h5B + 8'h81);
      add_byte(b);
      e_imm = e_imm | (32'(b) << (8 * i));
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic sop, input logic am, input logic [1:0] ai);
    @(negedge clk);
    in_valid = 1; in_byte = b; in_sop = sop; attr_modrm = am; attr_imm = ai;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_instr(input int stall);
    for (int i = 0; i < nb; i++) begin
      // R5: attributes are wrong on every byte but the final opcode byte
      if (i == opc_last) send_byte(ib[i], i == 0, e_am, e_ai);
      else               send_byte(ib[i], i == 0, ~e_am, ~e_ai);
    end
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 0, "R12 record early", 32'(out_valid), 0);
    chk(in_ready == 0, "R11 ready while forming", 32'(in_ready), 0);
    @(negedge clk);
    chk(out_valid == 1, "R12 record due", 32'(out_valid), 1);
    chk(out_lockrep == e_lr, "R1 lockrep", 32'(out_lockrep), 32'(e_lr));
    chk(out_seg == e_seg, "R1 seg", 32'(out_seg), 32'(e_seg));
    chk(out_dup == e_dup, "R2 dup", 32'(out_dup), 32'(e_dup));
    chk(out_two_byte == e_two, "R4 two_byte", 32'(out_two_byte), 32'(e_two));
    chk(out_opcode == e_opc, "R4 opcode", 32'(out_opcode), 32'(e_opc));
    chk(out_modrm_v == e_mv, "R5 modrm present", 32'(out_modrm_v), 32'(e_mv));
    chk({out_mod, out_reg, out_rm} == e_modrm, "R6 modrm fields",
        32'({out_mod, out_reg, out_rm}), 32'(e_modrm));
    chk(out_sib_v == e_sv, "R7 sib present", 32'(out_sib_v), 32'(e_sv));
    chk({out_scale, out_index, out_base} == e_sib, "R7 sib fields",
        32'({out_scale, out_index, out_base}), 32'(e_sib));
    chk(out_disp == e_disp, "R8 disp", out_disp, e_disp);
    chk(out_imm == e_imm, "R9 imm", out_imm, e_imm);
    chk(out_len == 5'(nb), "R10 len", 32'(out_len), 32'(nb));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid == 1 && in_ready == 0, "R11 held", 32'({out_valid, in_ready}), 32'h2);
      chk(out_disp == e_disp && out_len == 5'(nb), "R11 stable", out_disp, e_disp);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 0, "R11 released", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R11 reset valid", 32'(out_valid), 0);
    chk(in_ready == 1, "R11 reset ready", 32'(in_ready), 1);
    chk(err_flag == 0, "R11 reset err", 32'(err_flag), 0);

    k = 0;
    for (int md = 0; md < 4; md++)
      for (int rm = 0; rm < 8; rm++)
        for (int base = 0; base < ((md != 3 && rm == 4) ? 8 : 1); base++) begin
          begin_instr();
          add_pfx_set(k % 6);
          add_opcode(k[0], 8'h80 | 8'(k[5:0]), 1, 2'(k % 4));
          add_addr(md, k % 8, rm, base, k);
          add_imm(2'(k % 4), k);
          run_instr(k % 3);
          k++;
        end

    for (int two = 0; two < 2; two++)
      for (int ai = 0; ai < 4; ai++) begin
        begin_instr();
        add_pfx_set(k % 6);
        add_opcode(two[0], 8'hA0 | 8'(k[4:0]), 0, 2'(ai));
        add_imm(2'(ai), k);
        run_instr(1);
        k++;
      end

    // R10: longest form, four prefixes, escape opcode, index byte with base 5, 4+4 bytes
    begin_instr();
    add_pfx_set(3);
    add_opcode(1, 8'hAF, 1, 2'd3);
    add_addr(2, 3, 4, 5, 77);
    add_imm(2'd3, 77);
    run_instr(2);
    chk(nb == 16, "R10 longest form built", 32'(nb), 16);

    // R3: fifth prefix
    send_byte(8'hF0, 1, 0, 0);
    send_byte(8'hF3, 0, 0, 0);
    send_byte(8'h2E, 0, 0, 0);
    send_byte(8'h36, 0, 0, 0);
    send_byte(8'hF2, 0, 0, 0);
    @(negedge clk);
    in_valid = 0;
    chk(err_flag == 1, "R3 err pulse", 32'(err_flag), 1);
    chk(in_ready == 1, "R3 drop accepts", 32'(in_ready), 1);
    chk(out_valid == 0, "R3 no record", 32'(out_valid), 0);
    @(negedge clk);
    chk(err_flag == 0, "R3 err one cycle", 32'(err_flag), 0);
    send_byte(8'h90, 0, 0, 0);
    send_byte(8'hC3, 0, 0, 0);
    send_byte(8'hF0, 0, 0, 0);
    send_byte(8'h04, 0, 1, 2'd3);
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk(out_valid == 0 && err_flag == 0, "R3 dropped bytes silent", 32'({out_valid, err_flag}), 0);
      @(negedge clk);
    end

    // R3: restart on start marker with a full prefix count
    begin_instr();
    add_pfx(8'hF3); add_pfx(8'hF2); add_pfx(8'h36); add_pfx(8'h2E);
    add_opcode(0, 8'h90, 0, 2'd0);
    run_instr(0);

    // R3: in_sop mid-instruction has no effect
    begin_instr();
    add_opcode(0, 8'h8B, 1, 2'd1);
    add_addr(1, 2, 3, 0, 5);
    add_imm(2'd1, 5);
    for (int i = 0; i < nb; i++)
      send_byte(ib[i], 1, (i == opc_last) ? e_am : ~e_am, (i == opc_last) ? e_ai : ~e_ai);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 1, "R3 sop ignored record", 32'(out_valid), 1);
    chk(out_len == 5'(nb), "R3 sop ignored len", 32'(out_len), 32'(nb));
    chk(out_imm == e_imm, "R3 sop ignored imm", out_imm, e_imm);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;

    finished = 1;
    summary();
    $finish;
  end

endmodule